// File: doc/BRIEF.md
# Dual Event Counter With Select

This block holds two programmable 40-bit activity counters and one 64-bit selection register that steers both of them. For each counter the selection register carries a 6-bit event code, a mode flag that picks between counting every clock and counting occurrences of the chosen event, and two permission flags. One flag allows counting while the core runs at privilege level 3 (user). The other allows counting at levels 0 to 2 (supervisor).

The surrounding core supplies one strobe per event code every cycle, together with its current privilege level. The counters add one in each cycle that qualifies. Software accesses the selection register and both counters through a single write port and a single combinational read port. Each port uses a 2-bit register select.

Top module: `pcp_top`

## Requirements
- R1: After an asynchronous active-low reset, the selection register and both counters read zero, and neither counter advances until the selection register is written.
- R2: A register select of 0 addresses the selection register, 1 addresses counter 0 and 2 addresses counter 1. Writes with select 3 change nothing, and reads with select 3 return zero. A read is combinational and shows a write from the next cycle on.
- R3: Counter 0 takes its event code from selection bits 5..0. Bit 6 enables counting at privilege levels 0 to 2, bit 7 enables counting at level 3, and bit 8 selects cycle mode when 1 and event mode when 0.
- R4: Counter 1 uses the same layout shifted up by 16: code in bits 21..16, supervisor enable in bit 22, user enable in bit 23 and mode in bit 24.
- R5: Selection bits 15..9 and 63..25 are reserved. They ignore writes and read as zero.
- R6: A counter advances only when the enable matching the current privilege level is set. Level 3 uses the user enable, and levels 0, 1 and 2 use the supervisor enable.
- R7: In cycle mode, an enabled counter adds exactly one per clock.
- R8: In event mode, an enabled counter adds one in each cycle where the strobe bit whose index equals its event code is high.
- R9: Event codes 0x20, 0x21 and 0x2A to 0x3F are reserved and never advance the counter, in either mode. Codes 0x00 to 0x1F and 0x22 to 0x29 are valid.
- R10: Counters are 40 bits wide and wrap from all ones to zero without any indication. Read bits 63..40 of a counter are zero, and written bits 63..40 are dropped.
- R11: A write to a counter wins over an increment in the same cycle. A write to the selection register governs counting from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 selection, 1 counter 0, 2 counter 1 |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Read source, same encoding as wr_sel |
| rd_data | output | 64 | Combinational read data |
| evt_strobe | input | 64 | Per-cycle event strobes, bit n is event code n |
| priv_lvl | input | 2 | Current privilege level, 3 is user |

## Verification
The assertions check four things on every cycle. The reserved selection bits stay zero. A counter that is neither written nor qualified holds its value. A write lands exactly as issued, even when an increment is pending. A counter at all ones steps to zero. Assertions also check that a disallowed privilege or a reserved code freezes the counter, and that the upper read bits of a counter are zero. Whether the right strobe bit is chosen for each code, and how mode, enables and privilege combine, only shows up through the bench's scenarios. The bench drives several event patterns, privilege changes and field values, and its reference model is compared against every readable register after each clock.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  localparam int CODE_W   = 6;
  localparam int CFG_W    = CODE_W + 3;
  localparam int CH_PITCH = 16;
  localparam logic [1:0] PRIV_USER = 2'd3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT0 = 2'd1,
    SEL_CNT1 = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Per-channel field group, packed in its bit order inside the select register.
  typedef struct packed {
    logic              cyc_mode;
    logic              en_user;
    logic              en_sup;
    logic [CODE_W-1:0] code;
  } chan_cfg_t;

  // Bits of the select register that hold state.
  function automatic logic [63:0] ctrl_mask();
    logic [63:0] m;
    m = '0;
    for (int ch = 0; ch < 2; ch++)
      m[ch*CH_PITCH +: CFG_W] = '1;
    return m;
  endfunction

  function automatic chan_cfg_t cfg_of(input logic [63:0] ctrl, input int ch);
    return chan_cfg_t'(ctrl[ch*CH_PITCH +: CFG_W]);
  endfunction

  function automatic logic code_defined(input logic [CODE_W-1:0] c);
    return (c <= 6'h1F) || ((c >= 6'h22) && (c <= 6'h29));
  endfunction

  function automatic logic priv_allowed(input chan_cfg_t cfg, input logic [1:0] pl);
    return (pl == PRIV_USER) ? cfg.en_user : cfg.en_sup;
  endfunction

endpackage

// File: rtl/pcp_ctrl_reg.sv
module pcp_ctrl_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(pcp_pkg::ctrl_mask());

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata & MASK;
  end

  // R5: reserved bits never take a value
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~MASK) == '0);

  // R11: a write shows on the next cycle
  a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctrl_q == ($past(wdata) & MASK));

  // R1: no write, no change
  a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/pcp_chan.sv
module pcp_chan #(
  parameter int CNT_W   = 40,
  parameter int NUM_EVT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pcp_pkg::chan_cfg_t  cfg,
  input  logic [1:0]          priv_lvl,
  input  logic [NUM_EVT-1:0]  evt_strobe,
  input  logic                wr,
  input  logic [CNT_W-1:0]    wdata,
  output logic [CNT_W-1:0]    cnt_q,
  output logic                inc_o
);
  logic allowed;
  logic code_ok;
  logic hit;

  assign allowed = pcp_pkg::priv_allowed(cfg, priv_lvl);
  assign code_ok = pcp_pkg::code_defined(cfg.code);
  assign hit     = cfg.cyc_mode | evt_strobe[cfg.code];
  assign inc_o   = allowed & code_ok & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr)     cnt_q <= wdata;
    else if (inc_o)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R11: write wins over an increment
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wdata));

  // R7 / R8: no qualifying cycle, no change
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !inc_o) |=> $stable(cnt_q));

  // R9: reserved code freezes the counter
  a_r9_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !pcp_pkg::code_defined(cfg.code)) |=> $stable(cnt_q));

  // R6: a disallowed privilege freezes the counter
  a_r6_priv_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && ((priv_lvl == 2'd3) ? !cfg.en_user : !cfg.en_sup)) |=> $stable(cnt_q));

  // R10: silent wrap
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && inc_o && (cnt_q == '1)) |=> cnt_q == '0);
endmodule

// File: rtl/pcp_top.sv
module pcp_top #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 40,
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [1:0]         priv_lvl
);
  import pcp_pkg::*;

  localparam int NUM_CH = 2;
  localparam int PAD_W  = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [NUM_CH-1:0] cnt_wr;
  logic [NUM_CH-1:0] cnt_inc;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  pcp_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctrl_wr),
    .wdata  (wr_data),
    .ctrl_q (ctrl_q)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign cnt_wr[ch] = wr_en && (wr_sel == 2'(ch + 1));
    pcp_chan #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg_of(64'(ctrl_q), ch)),
      .priv_lvl   (priv_lvl),
      .evt_strobe (evt_strobe),
      .wr         (cnt_wr[ch]),
      .wdata      (wr_data[CNT_W-1:0]),
      .cnt_q      (cnt_q[ch]),
      .inc_o      (cnt_inc[ch])
    );
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_data = ctrl_q;
      SEL_CNT0: rd_data = {{PAD_W{1'b0}}, cnt_q[0]};
      SEL_CNT1: rd_data = {{PAD_W{1'b0}}, cnt_q[1]};
      default:  rd_data = '0;
    endcase
  end

  // R10: counter reads carry zero above the counter width
  always_comb begin
    if (rst_n && (rd_sel != SEL_CTRL))
      a_r10_upper_zero: assert (rd_data[DATA_W-1:CNT_W] == '0);
  end

  // R2: a write with the unused select changes no register
  a_r2_none_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE && cnt_inc == '0) |=>
      ($stable(ctrl_q) && $stable(cnt_q[0]) && $stable(cnt_q[1])));
endmodule

// File: tb/sim_pcp_top.sv
module sim_pcp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [63:0] rd_data;
  logic [63:0] evt_strobe = '0;
  logic [1:0]  priv_lvl = 2'd0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  longint unsigned m_ctrl = 0;
  longint unsigned m_cnt [2] = '{0, 0};
  localparam longint unsigned M40  = 64'h0000_00FF_FFFF_FFFF;
  localparam longint unsigned CMSK = 64'h0000_0000_01FF_01FF;

  always #5 clk = ~clk;

  pcp_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_strobe(evt_strobe), .priv_lvl(priv_lvl)
  );

  function automatic bit valid_code(int c);
    if (c < 32) return 1;
    return (c >= 34) && (c <= 41);
  endfunction

  task automatic check(string t, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      case (s)
        0: check({tag, " ctrl"}, rd_data, m_ctrl);
        1: check({tag, " cnt0"}, rd_data, m_cnt[0]);
        2: check({tag, " cnt1"}, rd_data, m_cnt[1]);
        default: check({tag, " R2 unused read"}, rd_data, 0);
      endcase
    end
  endtask

  // One clock: reference model advance, then compare every register.
  task automatic step();
    longint unsigned n_ctrl;
    longint unsigned n_cnt [2];
    n_ctrl = m_ctrl;
    for (int i = 0; i < 2; i++) begin
      longint unsigned f;
      int code;
      bit allow, hit;
      f = m_ctrl >> (16 * i);
      code = int'(f & 63);
      allow = (priv_lvl == 2'd3) ? f[7] : f[6];
      hit = f[8] ? 1'b1 : evt_strobe[code];
      if (wr_en && wr_sel == 2'(i + 1))
        n_cnt[i] = wr_data & M40;
      else if (allow && hit && valid_code(code))
        n_cnt[i] = (m_cnt[i] + 1) & M40;
      else
        n_cnt[i] = m_cnt[i];
    end
    if (wr_en && wr_sel == 2'd0) n_ctrl = wr_data & CMSK;
    @(posedge clk);
    m_ctrl = n_ctrl;
    m_cnt = n_cnt;
    #1;
    compare_all();
  endtask

  task automatic write(logic [1:0] sel, logic [63:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #200000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset values and no counting afterwards
    #12;
    compare_all();
    rst_n = 1'b1;
    priv_lvl = 2'd0; evt_strobe = '1;
    idle(3);

    // R5: reserved bits dropped, live fields kept (R3, R4 layout)
    tag = "R5";
    write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    write(2'd0, 64'h0);

    // R7 / R3: counter 0 cycle mode, supervisor enable (bit 6), mode bit 8
    tag = "R7";
    evt_strobe = '0;
    write(2'd0, 64'h0000_0000_0000_0140);
    idle(5);

    // R6: user level with user enable clear stops counting
    tag = "R6";
    priv_lvl = 2'd3; idle(3);
    priv_lvl = 2'd2; idle(2);
    // user enable only (bit 7)
    write(2'd0, 64'h0000_0000_0000_0180);
    priv_lvl = 2'd1; idle(2);
    priv_lvl = 2'd3; idle(3);

    // R8 / R3: counter 0 event mode on code 0x05, both enables
    tag = "R8";
    write(2'd0, 64'h0000_0000_0000_00C5);
    for (int k = 0; k < 12; k++) begin
      evt_strobe = '0;
      evt_strobe[5] = (k % 3) != 1;
      evt_strobe[4] = 1'b1;
      priv_lvl = 2'(k % 4);
      step();
    end

    // R4: counter 1 event code 0x29 with supervisor enable bit 22
    tag = "R4";
    write(2'd0, 64'h0000_0000_0069_0000);
    for (int k = 0; k < 10; k++) begin
      evt_strobe = 64'(k * 64'h0000_0300_0000_0000);
      priv_lvl = 2'(k % 4);
      step();
    end
    // counter 1 cycle mode, user only (bits 23, 24)
    write(2'd0, 64'h0000_0000_0180_0000);
    priv_lvl = 2'd3; idle(4);
    priv_lvl = 2'd0; idle(2);

    // R9: reserved codes 0x20, 0x21, 0x2A, 0x3F do not count in either mode
    tag = "R9";
    evt_strobe = '1; priv_lvl = 2'd0;
    write(2'd0, 64'h0000_0000_00EA_00E0);
    idle(3);
    write(2'd0, 64'h0000_0000_01FF_01E1);
    idle(3);
    write(2'd0, 64'h0000_0000_00E2_00DF);
    idle(3);

    // R10: wrap at 40 bits and upper write bits dropped
    tag = "R10";
    write(2'd1, 64'hABCD_00FF_FFFF_FFFE);
    write(2'd0, 64'h0000_0000_0000_01C0);
    idle(4);

    // R11: write beats increment; ctrl write governs from next cycle
    tag = "R11";
    write(2'd1, 64'h0000_0012_3456_789A);
    write(2'd0, 64'h0);
    idle(2);
    write(2'd0, 64'h0000_0000_01C0_0000);
    write(2'd2, 64'h0000_0000_0000_0010);
    idle(2);

    // R2: unused select writes nothing
    tag = "R2";
    write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule